// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces the per-line clamp-enable pulse that restores the black level of three video channels ahead of their converters. It runs entirely in the pixel-clock domain. The horizontal sync input is resynchronised, and the block finds the end of each sync pulse, which is the trailing edge. A programmable number of pixel clocks later it raises the clamp, and it holds the clamp for a programmable number of pixel clocks. The sync polarity is programmable, so the trailing edge is the rising transition for active-low sync and the falling transition for active-high sync.

A source-select setting can replace the internally timed pulse with an external clamp input. That input is resynchronised, and its active level is programmable. In every mode the result is one registered, active-high clamp signal. All settings are captured together from the configuration inputs on a cycle where the load strobe is high. Between loads the captured values hold.

Top module: `line_clamp_gen`

## Requirements
- R1: After reset, clamp_out is 0, the sync is treated as active high, the internal source is selected, the external clamp is treated as active high, the placement is 4 and the duration is 8.
- R2: With cfg_sync_act_hi = 1, only a high-to-low transition of hsync_in starts a clamp sequence. A low-to-high transition does not.
- R3: With cfg_sync_act_hi = 0, only a low-to-high transition of hsync_in starts a clamp sequence. A high-to-low transition does not.
- R4: Let edge k be the first rising clock edge that samples the trailing transition of hsync_in, with placement P and duration W > 0 in effect. In internal mode clamp_out is 1 after edges k+P+3 through k+P+W+2 and is 0 otherwise. This holds from P = 0 up to P = 255.
- R5: A duration of 0 produces no clamp pulse, and a trailing edge seen with duration 0 ends any sequence already in progress.
- R6: A trailing edge that arrives during the placement count or during the clamp pulse restarts the sequence from that edge. Any remaining part of the earlier pulse is dropped.
- R7: With cfg_use_ext = 1, clamp_out after edge m equals 1 exactly when ext_clamp_in sampled at edge m-2 equals cfg_ext_act_hi. A value of 1 means high is active and 0 means low is active.
- R8: All five settings are taken only at an edge where cfg_load = 1, and take effect one edge later. Changes on the configuration inputs while cfg_load = 0 have no effect. The placement and duration of a sequence are fixed at its trailing edge, so a later load does not alter a sequence already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| ext_clamp_in | input | 1 | External clamp request, asynchronous |
| cfg_load | input | 1 | Captures all configuration inputs at this edge |
| cfg_sync_act_hi | input | 1 | 1: sync active high, 0: sync active low |
| cfg_use_ext | input | 1 | 1: external clamp source, 0: internal timing |
| cfg_ext_act_hi | input | 1 | 1: external clamp active high, 0: active low |
| cfg_place | input | 8 | Pixel clocks from the trailing edge to the clamp start |
| cfg_width | input | 8 | Pixel clocks that the clamp stays asserted |
| clamp_out | output | 1 | Registered active-high clamp enable |

## Verification
A placement counter that loads or counts wrongly moves the whole clamp window. The fault then shows on clamp_out on the first line after the wrong load, within P+W+3 clocks of the trailing edge. A wrong edge-detector state or a wrong polarity choice makes the pulse start from the leading edge instead. The window then sits early by the sync width, or is missing entirely. A fault in the external path or the source mux shows two clocks after the input changes. The bench predicts clamp_out for every clock and compares it on every clock, so any of these faults appears on the line where it first occurs.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

  typedef struct packed {
    logic sync_act_hi;
    logic use_ext;
    logic ext_act_hi;
  } lcg_mode_t;

  localparam lcg_mode_t LCG_MODE_RST = '{sync_act_hi: 1'b1, use_ext: 1'b0, ext_act_hi: 1'b1};

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_PLACE = 2'd1,
    TMR_HOLD  = 2'd2
  } lcg_tmr_st_t;

  // Trailing edge: the previous level was active and the current one is not.
  function automatic logic lcg_is_trailing(input logic prev_lvl, input logic cur_lvl,
                                           input logic act_hi);
    return (prev_lvl == act_hi) && (cur_lvl != act_hi);
  endfunction

  // External request asserted when its level matches the programmed active level.
  function automatic logic lcg_ext_asserted(input logic lvl, input logic act_hi);
    return lvl == act_hi;
  endfunction

endpackage

// File: rtl/lcg_sync.sv
module lcg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lcg_cfg.sv
module lcg_cfg
  import lcg_pkg::*;
#(
  parameter int          CW        = 8,
  parameter logic [CW-1:0] RST_PLACE = CW'(4),
  parameter logic [CW-1:0] RST_WIDTH = CW'(8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  lcg_mode_t     mode_d,
  input  logic [CW-1:0] place_d,
  input  logic [CW-1:0] width_d,
  output lcg_mode_t     mode_q,
  output logic [CW-1:0] place_q,
  output logic [CW-1:0] width_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= LCG_MODE_RST;
      place_q <= RST_PLACE;
      width_q <= RST_WIDTH;
    end else if (load) begin
      mode_q  <= mode_d;
      place_q <= place_d;
      width_q <= width_d;
    end
  end
endmodule

// File: rtl/lcg_edge.sv
module lcg_edge
  import lcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl,
  input  logic act_hi,
  output logic trail
);
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= sync_lvl;
  end

  assign trail = lcg_is_trailing(prev_lvl, sync_lvl, act_hi);
endmodule

// File: rtl/lcg_timer.sv
module lcg_timer
  import lcg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trail,
  input  logic [CW-1:0] place,
  input  logic [CW-1:0] width,
  output logic          hold_active
);
  localparam logic [CW-1:0] ONE = CW'(1);

  lcg_tmr_st_t   st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wlat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TMR_IDLE;
      cnt_q  <= '0;
      wlat_q <= '0;
    end else if (trail) begin
      wlat_q <= width;
      if (width == '0) begin
        st_q  <= TMR_IDLE;
        cnt_q <= '0;
      end else if (place == '0) begin
        st_q  <= TMR_HOLD;
        cnt_q <= width;
      end else begin
        st_q  <= TMR_PLACE;
        cnt_q <= place;
      end
    end else begin
      case (st_q)
        TMR_PLACE: begin
          if (cnt_q == ONE) begin
            st_q  <= TMR_HOLD;
            cnt_q <= wlat_q;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        TMR_HOLD: begin
          if (cnt_q == ONE) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: begin
          st_q  <= TMR_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign hold_active = (st_q == TMR_HOLD);
endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import lcg_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          ext_clamp_in,
  input  logic          cfg_load,
  input  logic          cfg_sync_act_hi,
  input  logic          cfg_use_ext,
  input  logic          cfg_ext_act_hi,
  input  logic [CW-1:0] cfg_place,
  input  logic [CW-1:0] cfg_width,
  output logic          clamp_out
);
  localparam int NIN = 2;

  lcg_mode_t     mode_d, mode_q;
  logic [CW-1:0] place_q, width_q;
  logic [NIN-1:0] raw_in, syn_in;
  logic          sync_s2, ext_s2;
  logic          trail_evt;
  logic          hold_active;
  logic          clamp_next;

  assign mode_d = '{sync_act_hi: cfg_sync_act_hi, use_ext: cfg_use_ext,
                    ext_act_hi: cfg_ext_act_hi};

  lcg_cfg #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .mode_d(mode_d), .place_d(cfg_place), .width_d(cfg_width),
    .mode_q(mode_q), .place_q(place_q), .width_q(width_q)
  );

  assign raw_in = {ext_clamp_in, hsync_in};

  lcg_sync #(.STAGES(SYNC_STAGES), .WIDTH(NIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign sync_s2 = syn_in[0];
  assign ext_s2  = syn_in[1];

  lcg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_s2),
    .act_hi(mode_q.sync_act_hi), .trail(trail_evt)
  );

  lcg_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .trail(trail_evt),
    .place(place_q), .width(width_q), .hold_active(hold_active)
  );

  assign clamp_next = mode_q.use_ext ? lcg_ext_asserted(ext_s2, mode_q.ext_act_hi)
                                     : hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_out <= 1'b0;
    else        clamp_out <= clamp_next;
  end
endmodule

// File: rtl/lcg_checker.sv
module lcg_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trail,
  input logic          sync_s2,
  input logic          sync_act_hi,
  input logic          use_ext,
  input logic          ext_act_hi,
  input logic          ext_s2,
  input logic [CW-1:0] place_q,
  input logic [CW-1:0] width_q,
  input logic          hold_active,
  input logic          clamp_out
);
  // R1: first sampled cycle out of reset shows no clamp
  a_r1_reset_quiet: assert property (@(posedge clk) $rose(rst_n) |-> !clamp_out);

  // R2 and R3: a detected edge leaves the sync at its inactive level
  a_r2_r3_trail_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    trail |-> (sync_s2 != sync_act_hi));

  a_r2_r3_trail_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && $stable(sync_act_hi)) |-> ($past(sync_s2) == sync_act_hi));

  a_r4_place_zero_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && place_q == '0 && width_q != '0) |=> hold_active);

  a_r4_place_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && place_q != '0) |=> !hold_active);

  a_r5_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && width_q == '0) |=> !hold_active);

  a_r4_internal_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext && $past(!use_ext)) |-> (clamp_out == $past(hold_active)));

  a_r7_external_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ext && $past(use_ext)) |-> (clamp_out == ($past(ext_s2) == $past(ext_act_hi))));
endmodule

bind line_clamp_gen lcg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trail(trail_evt), .sync_s2(sync_s2),
  .sync_act_hi(mode_q.sync_act_hi), .use_ext(mode_q.use_ext),
  .ext_act_hi(mode_q.ext_act_hi), .ext_s2(ext_s2),
  .place_q(place_q), .width_q(width_q), .hold_active(hold_active),
  .clamp_out(clamp_out)
);

// File: tb/sim_line_clamp_gen.sv
`timescale 1ns/1ps
module sim_line_clamp_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic       ext_clamp_in = 1'b0;
  logic       cfg_load = 1'b0;
  logic       cfg_sync_act_hi = 1'b1;
  logic       cfg_use_ext = 1'b0;
  logic       cfg_ext_act_hi = 1'b1;
  logic [7:0] cfg_place = 8'd4;
  logic [7:0] cfg_width = 8'd8;
  logic       clamp_out;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  line_clamp_gen u0 (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
    .cfg_load(cfg_load), .cfg_sync_act_hi(cfg_sync_act_hi), .cfg_use_ext(cfg_use_ext),
    .cfg_ext_act_hi(cfg_ext_act_hi), .cfg_place(cfg_place), .cfg_width(cfg_width),
    .clamp_out(clamp_out)
  );

  // Reference model: sampled histories, a single clamp window, configuration as held.
  int m = 0;
  int h1 = 0, h2 = 0, h3 = 0;
  int e1 = 0, e2 = 0;
  int win_on = 1, win_off = 0;
  int c_hi = 1, c_ext = 0, c_epol = 1, c_place = 4, c_width = 8;
  bit exp_q = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m = 0; h1 = 0; h2 = 0; h3 = 0; e1 = 0; e2 = 0;
      win_on = 1; win_off = 0;
      c_hi = 1; c_ext = 0; c_epol = 1; c_place = 4; c_width = 8;
      exp_q = 0;
    end else begin
      m++;
      if (c_ext != 0) exp_q = (e2 == c_epol);
      else            exp_q = (m >= win_on) && (m <= win_off);
      if (h3 == c_hi && h2 != c_hi) begin
        win_on  = m + c_place + 1;
        win_off = m + c_place + c_width;
      end
      h3 = h2; h2 = h1; h1 = int'(hsync_in);
      e2 = e1; e1 = int'(ext_clamp_in);
      if (cfg_load) begin
        c_hi = int'(cfg_sync_act_hi); c_ext = int'(cfg_use_ext);
        c_epol = int'(cfg_ext_act_hi);
        c_place = int'(cfg_place); c_width = int'(cfg_width);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (clamp_out !== exp_q) begin
        bad++;
        $display("FAIL %s cycle %0d: clamp_out actual=%0b expected=%0b", tag, m, clamp_out, exp_q);
      end
    end
  end

  task automatic load(input bit hi, input bit ext, input bit epol, input int p, input int w);
    @(negedge clk);
    cfg_sync_act_hi = hi; cfg_use_ext = ext; cfg_ext_act_hi = epol;
    cfg_place = 8'(p); cfg_width = 8'(w); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic line(input bit act, input int act_len, input int idle_len);
    @(negedge clk); hsync_in = act;
    repeat (act_len) @(negedge clk);
    hsync_in = ~act;
    repeat (idle_len) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (clamp_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: clamp_out actual=%0b expected=0", clamp_out);
    end
    tag = "R1";
    repeat (3) line(1'b1, 6, 30);
    tag = "R2";
    load(1, 0, 1, 5, 6);
    repeat (4) line(1'b1, 10, 40);
    line(1'b1, 2, 25);
    tag = "R3";
    load(0, 0, 1, 7, 9);
    repeat (4) line(1'b0, 10, 40);
    tag = "R4";
    load(0, 0, 1, 0, 1);
    repeat (3) line(1'b0, 4, 20);
    load(0, 0, 1, 255, 3);
    repeat (2) line(1'b0, 5, 280);
    load(1, 0, 1, 1, 255);
    line(1'b1, 3, 270);
    tag = "R5";
    load(1, 0, 1, 6, 0);
    repeat (3) line(1'b1, 5, 30);
    load(1, 0, 1, 3, 40);
    line(1'b1, 4, 10);
    load(1, 0, 1, 3, 0);
    line(1'b1, 4, 60);
    tag = "R6";
    load(1, 0, 1, 20, 30);
    repeat (3) line(1'b1, 3, 10);
    line(1'b1, 3, 30);
    repeat (3) line(1'b1, 3, 35);
    line(1'b1, 3, 80);
    tag = "R7";
    load(1, 1, 1, 5, 5);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      ext_clamp_in = (i % 7) < 3;
      hsync_in = (i % 20) < 4;
    end
    load(1, 1, 0, 5, 5);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      ext_clamp_in = (i % 5) < 2;
    end
    tag = "R8";
    load(1, 0, 1, 10, 12);
    @(negedge clk);
    cfg_place = 8'd1; cfg_width = 8'd0; cfg_use_ext = 1'b1; cfg_sync_act_hi = 1'b0;
    repeat (3) line(1'b1, 5, 40);
    line(1'b1, 5, 4);
    load(1, 0, 1, 2, 3);
    repeat (40) @(negedge clk);
    line(1'b1, 5, 30);
    load(1, 1, 1, 2, 3);
    repeat (10) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule